// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register File

This block is the software-visible register front end of an I/O interrupt controller. Software reaches everything through two word-wide offsets. It writes an 8-bit index into a select register, then reads or writes a data window. The index picks one of three things: a version word, a 4-bit controller identifier (also readable through an arbitration alias), or one half of a 64-bit redirection entry. Each interrupt pin has one such entry, and each entry takes two consecutive indexes starting at 0x10.

The block stores the table and presents the decoded fields of every entry on flat output buses. The servicing logic reads the vector, delivery mode, destination mode, trigger mode, mask, destination, remote-IRR and delivery status from these buses. That logic owns the remote-IRR and delivery-status bits and sets them through a small update port. Software writes never disturb these two bits, with one exception: after any write, an entry left in edge mode has its remote-IRR bit cleared. When a write changes an entry's mask, or leaves the entry level-triggered, the block sends a one-cycle notice with the entry number so that the servicing logic can look at that pin again.

The register port is a plain single-cycle strobe interface with no back-pressure. A read returns its data on `rdata` in the cycle after `rd_en` is sampled, and `rdata` holds that value until the next read. A status update and a software write may target the same entry in the same cycle. In that case the update supplies the two status bits, and the edge rule is then applied to the result.

Top module: `ioredir_regs`

## Requirements
- R1: A write at offset 0x00 stores bits 7:0 of `wdata` as the select index, and a read at offset 0x00 returns that index zero-extended.
- R2: With select index 0x01, a window read returns NUM_PINS-1 in bits 23:16 and VERSION_CODE in bits 7:0 with all other bits zero. Window writes at this index change nothing.
- R3: With select index 0x00, the window holds a 4-bit identifier in bits 27:24. Reads return it there with all other bits zero, and writes capture `wdata[27:24]`. Index 0x02 reads the same value, and writes to it are ignored.
- R4: An index of 0x10 or above addresses entry (index-0x10)>>1. An odd index reaches entry bits 63:32 and an even index reaches bits 31:0. A write replaces only the addressed half.
- R5: A window read at an index that maps to an entry number of NUM_PINS or more returns 0xFFFFFFFF, and so does a read at an index from 0x03 to 0x0F. Window writes at those indexes change nothing.
- R6: A software write leaves entry bits 12 (delivery status) and 14 (remote IRR) at their prior values, whatever `wdata` holds there.
- R7: After any software write to an entry, if bit 15 (trigger mode, 1 = level) is 0, then bit 14 reads 0.
- R8: After reset, the select index and the identifier are zero. Every entry is 0x00000000_00010000, which means mask bit 16 is set and all other bits are clear. `chg_valid` is low.
- R9: Reads at any offset other than 0x00 and 0x10 return zero, and writes there are ignored.
- R10: In the cycle after a window write to an in-range entry, `chg_valid` pulses for one cycle with `chg_pin` set to that entry. This happens if the write changed mask bit 16, or if the entry's bit 15 is 1 after the write. No other access produces the pulse.
- R11: When `upd_en` is high, entry `upd_pin` takes `upd_rirr` into bit 14 and `upd_dstat` into bit 12 at the next clock edge.
- R12: For entry i, the field buses carry the following bits of that entry: vector bits 7:0 on `ent_vector[8i+7:8i]`, delivery mode bits 10:8 on `ent_dmode[3i+2:3i]`, destination mode bit 11, delivery status bit 12, remote IRR bit 14, trigger mode bit 15, mask bit 16, and destination bits 63:56 on `ent_dest[8i+7:8i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| upd_en | input | 1 | Status update strobe from servicing logic |
| upd_pin | input | PIN_W | Entry targeted by the status update |
| upd_rirr | input | 1 | New remote-IRR value |
| upd_dstat | input | 1 | New delivery-status value |
| ent_vector | output | 8*NUM_PINS | Vector of each entry |
| ent_dmode | output | 3*NUM_PINS | Delivery mode of each entry |
| ent_destmode | output | NUM_PINS | Destination mode of each entry |
| ent_dstat | output | NUM_PINS | Delivery status of each entry |
| ent_rirr | output | NUM_PINS | Remote IRR of each entry |
| ent_level | output | NUM_PINS | Trigger mode of each entry (1 = level) |
| ent_mask | output | NUM_PINS | Mask of each entry |
| ent_dest | output | 8*NUM_PINS | Destination of each entry |
| chg_valid | output | 1 | One-cycle re-evaluate notice |
| chg_pin | output | PIN_W | Entry named by the notice |

## Verification
Every result in this block lands one clock edge after the stimulus that causes it. A register read places its word on `rdata` at the edge that samples `rd_en`. A window write updates the table, the field buses and `chg_valid`/`chg_pin` at its own edge. A status update appears on `ent_rirr`/`ent_dstat` at its edge. The bench drives each access on a falling edge and releases it on the next falling edge, and it compares at that second falling edge, half a period after the single edge that produced the result. `chg_valid` is checked in exactly that window, before any later access can raise or drop it.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;

  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_ARB  = 8'h02;
  localparam logic [7:0] IDX_TBL0 = 8'h10;

  localparam int B_DSTAT = 12;
  localparam int B_RIRR  = 14;
  localparam int B_LEVEL = 15;
  localparam int B_MASK  = 16;

  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef struct packed {
    logic       is_id;
    logic       is_ver;
    logic       is_arb;
    logic       is_ent;
    logic       hi;
    logic [6:0] idx;
  } sel_dec_t;
endpackage

// File: rtl/ioredir_seldec.sv
module ioredir_seldec
  import ioredir_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic [7:0] sel,
  output sel_dec_t   dec
);
  localparam logic [7:0] NP8 = 8'(NUM_PINS);

  logic [7:0] off;

  always_comb begin
    off        = sel - IDX_TBL0;
    dec        = '0;
    dec.idx    = off[7:1];
    dec.hi     = sel[0];
    dec.is_id  = (sel == IDX_ID);
    dec.is_ver = (sel == IDX_VER);
    dec.is_arb = (sel == IDX_ARB);
    dec.is_ent = (sel >= IDX_TBL0) && ({1'b0, off[7:1]} < NP8);
  end
endmodule

// File: rtl/ioredir_entry.sv
module ioredir_entry
  import ioredir_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        upd,
  input  logic        upd_rirr,
  input  logic        upd_dstat,
  output logic [63:0] q,
  output logic        chg_req
);
  logic [63:0] nxt;
  logic        wr_any;

  assign wr_any = wr_lo | wr_hi;

  always_comb begin
    nxt = q;
    if (wr_lo) nxt[31:0]  = wdata;
    if (wr_hi) nxt[63:32] = wdata;
    nxt[B_DSTAT] = q[B_DSTAT];
    nxt[B_RIRR]  = q[B_RIRR];
    if (upd) begin
      nxt[B_DSTAT] = upd_dstat;
      nxt[B_RIRR]  = upd_rirr;
    end
    if (wr_any && !nxt[B_LEVEL]) nxt[B_RIRR] = 1'b0;
    chg_req = wr_any && ((nxt[B_MASK] != q[B_MASK]) || nxt[B_LEVEL]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= ENTRY_RST;
    else        q <= nxt;
  end

  // R6: software writes keep the status bits unless the edge rule applies
  a_r6_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !upd) |=> (q[B_DSTAT] == $past(q[B_DSTAT])) &&
                         (!q[B_LEVEL] || q[B_RIRR] == $past(q[B_RIRR])));

  // R7: an entry left in edge mode after a write has remote IRR clear
  a_r7_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> (q[B_LEVEL] || !q[B_RIRR]));

  // R11: the update port sets both status bits at the next edge
  a_r11_update_applied: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr_any) |=> (q[B_RIRR] == $past(upd_rirr)) &&
                         (q[B_DSTAT] == $past(upd_dstat)));
endmodule

// File: rtl/ioredir_rdmux.sv
module ioredir_rdmux
  import ioredir_pkg::*;
#(
  parameter int         NUM_PINS     = 24,
  parameter logic [7:0] VERSION_CODE = 8'h20,
  parameter int         PIN_W        = $clog2(NUM_PINS)
) (
  input  logic [7:0]  addr,
  input  logic [7:0]  sel,
  input  sel_dec_t    dec,
  input  logic [3:0]  id,
  input  logic [63:0] tbl [NUM_PINS],
  output logic [31:0] rd_val
);
  localparam logic [7:0] MAXPIN = 8'(NUM_PINS - 1);

  logic [63:0] ent;
  logic [31:0] win;

  always_comb begin
    ent = tbl[dec.idx[PIN_W-1:0]];
    if (dec.is_ent)                  win = dec.hi ? ent[63:32] : ent[31:0];
    else if (dec.is_ver)             win = {8'h00, MAXPIN, 8'h00, VERSION_CODE};
    else if (dec.is_id | dec.is_arb) win = {4'h0, id, 24'h0};
    else                             win = 32'hFFFF_FFFF;

    if (addr == OFS_SEL)      rd_val = {24'h0, sel};
    else if (addr == OFS_WIN) rd_val = win;
    else                      rd_val = 32'h0;
  end
endmodule

// File: rtl/ioredir_regs.sv
module ioredir_regs
  import ioredir_pkg::*;
#(
  parameter int         NUM_PINS     = 24,
  parameter logic [7:0] VERSION_CODE = 8'h20,
  parameter int         PIN_W        = $clog2(NUM_PINS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [7:0]            addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic                  upd_en,
  input  logic [PIN_W-1:0]      upd_pin,
  input  logic                  upd_rirr,
  input  logic                  upd_dstat,
  output logic [8*NUM_PINS-1:0] ent_vector,
  output logic [3*NUM_PINS-1:0] ent_dmode,
  output logic [NUM_PINS-1:0]   ent_destmode,
  output logic [NUM_PINS-1:0]   ent_dstat,
  output logic [NUM_PINS-1:0]   ent_rirr,
  output logic [NUM_PINS-1:0]   ent_level,
  output logic [NUM_PINS-1:0]   ent_mask,
  output logic [8*NUM_PINS-1:0] ent_dest,
  output logic                  chg_valid,
  output logic [PIN_W-1:0]      chg_pin
);
  logic [7:0]          sel_q;
  logic [3:0]          id_q;
  sel_dec_t            dec;
  logic [63:0]         tbl [NUM_PINS];
  logic [NUM_PINS-1:0] chg_req;
  logic [31:0]         rd_val;
  logic                sel_wr, win_wr;

  assign sel_wr = wr_en && (addr == OFS_SEL);
  assign win_wr = wr_en && (addr == OFS_WIN);

  ioredir_seldec #(.NUM_PINS(NUM_PINS)) u_dec (
    .sel (sel_q),
    .dec (dec)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    logic hit;
    assign hit = win_wr && dec.is_ent && (dec.idx[PIN_W-1:0] == PIN_W'(i));

    ioredir_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (hit && !dec.hi),
      .wr_hi     (hit && dec.hi),
      .wdata     (wdata),
      .upd       (upd_en && (upd_pin == PIN_W'(i))),
      .upd_rirr  (upd_rirr),
      .upd_dstat (upd_dstat),
      .q         (tbl[i]),
      .chg_req   (chg_req[i])
    );

    assign ent_vector[8*i +: 8] = tbl[i][7:0];
    assign ent_dmode[3*i +: 3]  = tbl[i][10:8];
    assign ent_destmode[i]      = tbl[i][11];
    assign ent_dstat[i]         = tbl[i][B_DSTAT];
    assign ent_rirr[i]          = tbl[i][B_RIRR];
    assign ent_level[i]         = tbl[i][B_LEVEL];
    assign ent_mask[i]          = tbl[i][B_MASK];
    assign ent_dest[8*i +: 8]   = tbl[i][63:56];
  end

  ioredir_rdmux #(
    .NUM_PINS     (NUM_PINS),
    .VERSION_CODE (VERSION_CODE),
    .PIN_W        (PIN_W)
  ) u_rd (
    .addr   (addr),
    .sel    (sel_q),
    .dec    (dec),
    .id     (id_q),
    .tbl    (tbl),
    .rd_val (rd_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      id_q      <= '0;
      rdata     <= '0;
      chg_valid <= 1'b0;
      chg_pin   <= '0;
    end else begin
      if (sel_wr)                 sel_q <= wdata[7:0];
      if (win_wr && dec.is_id)    id_q  <= wdata[27:24];
      if (rd_en)                  rdata <= rd_val;
      chg_valid <= |chg_req;
      chg_pin   <= dec.idx[PIN_W-1:0];
    end
  end

  // R1: the select register captures the low data byte
  a_r1_sel_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel_q == $past(wdata[7:0])));

  // R10: the notice follows only a window write and lasts one cycle per write
  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> $past(win_wr));

  // R5: the notice never names an entry beyond the table
  a_r5_pin_range: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> (32'(chg_pin) < NUM_PINS));

  // R9: writes at unused offsets leave the select register alone
  a_r9_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != OFS_SEL) |=> $stable(sel_q));
endmodule

// File: tb/ioredir_regs_tb.sv
module ioredir_regs_tb;
  localparam int NP    = 24;
  localparam int PW    = $clog2(NP);
  localparam int NVEC  = 35;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            upd_en = 1'b0, upd_rirr = 1'b0, upd_dstat = 1'b0;
  logic [PW-1:0]   upd_pin = '0;
  logic [8*NP-1:0] ent_vector, ent_dest;
  logic [3*NP-1:0] ent_dmode;
  logic [NP-1:0]   ent_destmode, ent_dstat, ent_rirr, ent_level, ent_mask;
  logic            chg_valid;
  logic [PW-1:0]   chg_pin;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ioredir_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .upd_en(upd_en), .upd_pin(upd_pin),
    .upd_rirr(upd_rirr), .upd_dstat(upd_dstat), .ent_vector(ent_vector),
    .ent_dmode(ent_dmode), .ent_destmode(ent_destmode), .ent_dstat(ent_dstat),
    .ent_rirr(ent_rirr), .ent_level(ent_level), .ent_mask(ent_mask),
    .ent_dest(ent_dest), .chg_valid(chg_valid), .chg_pin(chg_pin)
  );

  // {op, offset, data-or-expected}; op 1 = write, 2 = read and compare
  localparam logic [41:0] VEC [NVEC] = '{
    {2'd1, 8'h00, 32'h0000_0001},  // R1 select version
    {2'd2, 8'h10, 32'h0017_0020},  // R2 version word
    {2'd1, 8'h10, 32'hFFFF_FFFF},  // R2 write ignored
    {2'd2, 8'h10, 32'h0017_0020},  // R2
    {2'd2, 8'h00, 32'h0000_0001},  // R1 readback
    {2'd1, 8'h00, 32'h1234_5600},  // R1 low byte only
    {2'd2, 8'h00, 32'h0000_0000},  // R1
    {2'd1, 8'h10, 32'hF500_0000},  // R3 id write
    {2'd2, 8'h10, 32'h0500_0000},  // R3
    {2'd1, 8'h00, 32'h0000_0002},  // R3 arbitration alias
    {2'd2, 8'h10, 32'h0500_0000},  // R3
    {2'd1, 8'h10, 32'h0A00_0000},  // R3 alias write ignored
    {2'd2, 8'h10, 32'h0500_0000},  // R3
    {2'd1, 8'h00, 32'h0000_0010},  // R4 entry 0 low
    {2'd2, 8'h10, 32'h0001_0000},  // R8 reset entry
    {2'd1, 8'h10, 32'h0000_5F31},  // R6 status bits in data
    {2'd2, 8'h10, 32'h0000_0F31},  // R6
    {2'd1, 8'h00, 32'h0000_0011},  // R4 entry 0 high
    {2'd1, 8'h10, 32'hA500_0000},  // R4
    {2'd2, 8'h10, 32'hA500_0000},  // R4
    {2'd1, 8'h00, 32'h0000_0010},  // R4 low half untouched
    {2'd2, 8'h10, 32'h0000_0F31},  // R4
    {2'd1, 8'h00, 32'h0000_0040},  // R5 entry NP
    {2'd2, 8'h10, 32'hFFFF_FFFF},  // R5
    {2'd1, 8'h10, 32'h0000_0000},  // R5 write ignored
    {2'd2, 8'h10, 32'hFFFF_FFFF},  // R5
    {2'd1, 8'h00, 32'h0000_0005},  // R5 gap index
    {2'd2, 8'h10, 32'hFFFF_FFFF},  // R5
    {2'd1, 8'h00, 32'h0000_003F},  // R4 last entry high
    {2'd2, 8'h10, 32'h0000_0000},  // R8
    {2'd1, 8'h00, 32'h0000_003E},  // R4 last entry low
    {2'd2, 8'h10, 32'h0001_0000},  // R8
    {2'd2, 8'h20, 32'h0000_0000},  // R9 unused offset
    {2'd1, 8'h20, 32'h0000_0055},  // R9 write ignored
    {2'd2, 8'h00, 32'h0000_003E}   // R9 select unchanged
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(ent_mask == '1, "R8 masks", 32'(ent_mask), 32'(24'hFFFFFF));
    chk(chg_valid == 1'b0, "R8 chg_valid", 32'(chg_valid), 32'd0);
    chk(ent_rirr == '0 && ent_level == '0, "R8 status", 32'(ent_rirr), 32'd0);
    do_rd(8'h00, 32'h0, "R8 select");

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][41:40] == 2'd1) do_wr(VEC[k][39:32], VEC[k][31:0]);
      else do_rd(VEC[k][39:32], VEC[k][31:0], $sformatf("table step %0d", k));
    end

    // R12 field buses for entry 0 (vector 0x31, mode 7, destmode 1, dest 0xA5)
    chk(ent_vector[7:0] == 8'h31, "R12 vector", 32'(ent_vector[7:0]), 32'h31);
    chk(ent_dmode[2:0] == 3'd7, "R12 dmode", 32'(ent_dmode[2:0]), 32'd7);
    chk(ent_destmode[0] == 1'b1, "R12 destmode", 32'(ent_destmode[0]), 32'd1);
    chk(ent_mask[0] == 1'b0, "R12 mask", 32'(ent_mask[0]), 32'd0);
    chk(ent_dest[7:0] == 8'hA5, "R12 dest", 32'(ent_dest[7:0]), 32'hA5);

    // R10 mask change on entry 0 raises the notice
    do_wr(8'h00, 32'h10);
    do_wr(8'h10, 32'h0001_0F31);
    chk(chg_valid && chg_pin == 0, "R10 mask change", {chg_valid, 31'(chg_pin)}, 32'h8000_0000);
    // R10 edge write with unchanged mask: no notice
    do_wr(8'h00, 32'h12);
    do_wr(8'h10, 32'h0001_0040);
    chk(!chg_valid, "R10 quiet edge", 32'(chg_valid), 32'd0);
    do_wr(8'h10, 32'h0001_8040);
    chk(chg_valid && chg_pin == 1, "R10 level", {chg_valid, 31'(chg_pin)}, 32'h8000_0001);
    do_wr(8'h00, 32'h13);
    chk(!chg_valid, "R10 select write", 32'(chg_valid), 32'd0);
    do_wr(8'h10, 32'h0);
    chk(chg_valid && chg_pin == 1, "R10 high half level", {chg_valid, 31'(chg_pin)}, 32'h8000_0001);

    // R11 status update
    @(negedge clk); upd_en = 1'b1; upd_pin = PW'(1); upd_rirr = 1'b1; upd_dstat = 1'b1;
    @(negedge clk); upd_en = 1'b0;
    chk(ent_rirr[1] && ent_dstat[1], "R11 update", {30'd0, ent_rirr[1], ent_dstat[1]}, 32'd3);
    do_wr(8'h00, 32'h12);
    do_rd(8'h10, 32'h0001_D040, "R11 readback");
    // R6 level write keeps both status bits
    do_wr(8'h10, 32'h0001_8041);
    do_rd(8'h10, 32'h0001_D041, "R6 level keep");
    // R7 edge write clears remote IRR, keeps delivery status
    do_wr(8'h10, 32'h0001_0041);
    do_rd(8'h10, 32'h0001_1041, "R7 edge clear");
    chk(!ent_level[1] && !ent_rirr[1] && ent_vector[15:8] == 8'h41, "R12 entry1",
        32'(ent_vector[15:8]), 32'h41);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule